// File: doc/BRIEF.md
# DMA Transfer Length Counter

This block holds the byte count for a SCSI controller's DMA engine. The host loads the count one byte lane at a time into shadow registers. These writes never disturb the live counter. A command byte with its DMA flag set copies the shadows into the live counter. If that command is the transfer opcode, the block also computes an effective transfer length and starts a transfer. The live counter then counts down as bytes cross a simple valid/ready handshake.

A count of zero stands for the full 2^16 bytes. The effective length is the smaller of that count and one other limit. In data phases the limit is the magnitude of the remaining phase length. In command phases the limit is a fixed cap of 32. The remaining phase length is signed: a negative value means data flows toward the device and moves up toward zero, and a positive value flows toward the host and moves down. The transfer waits while the DMA-enable input is low. On completion it raises the terminal-count flag, loads the completion code into the interrupt register and zeroes the live counter.

Top module: `tcnt_top`

## Requirements
- R1: After synchronous reset, live_count, xfer_len, phase_left and intr_code are 0, and tc, byte_ready and done are 0.
- R2: A host write with host_sel 0 loads the low shadow byte and with host_sel 1 loads the mid shadow byte. live_count does not change, and tc clears on the next cycle.
- R3: A host write with host_sel 2 is a command. When host_data bit 7 is set and no transfer is pending or active, live_count becomes {mid shadow, low shadow} on the next cycle. When bit 7 is clear, live_count is unchanged.
- R4: A DMA command whose bits 6:0 equal 0x10 starts a transfer. A live count of 0 counts as 65536. In data mode (cmd_mode 0), xfer_len = min(count, |phase_rem|).
- R5: In command mode (cmd_mode 1), xfer_len = min(count, 32).
- R6: Starting a transfer clears tc. The transfer stays pending with byte_ready low while dma_en is low. byte_ready is high only while a started transfer has bytes left and dma_en has been seen high.
- R7: Each accepted byte (byte_valid and byte_ready) lowers live_count by 1. In data mode it also moves phase_left one step toward zero: up when negative, down when positive. In command mode phase_left holds its captured value.
- R8: done is high in the cycle the last byte is accepted, or in the first active cycle of a zero-length transfer. On the next cycle tc is 1, intr_code is 0x10, live_count is 0, and the block is idle.
- R9: Command writes issued while a transfer is pending or active have no effect on live_count or on the transfer.
- R10: When a counter byte write and completion happen in the same cycle, tc ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_sel | input | SEL_W (2) | Target: 0 low byte, 1 mid byte, 2 command |
| host_data | input | 8 | Host write data |
| cmd_mode | input | 1 | Phase is a command phase (length cap 32) |
| phase_rem | input | PH_W (18) | Signed remaining phase length, negative toward device |
| dma_en | input | 1 | DMA enable; transfer waits while low |
| byte_valid | input | 1 | Memory side offers one byte this cycle |
| byte_ready | output | 1 | Counter accepts a byte this cycle |
| done | output | 1 | Transfer completes this cycle |
| live_count | output | CNT_W (16) | Live transfer counter |
| xfer_len | output | CNT_W+1 (17) | Effective length of the current or last transfer |
| tc | output | 1 | Terminal-count status flag |
| intr_code | output | 8 | Interrupt register, 0x10 after completion |
| phase_left | output | PH_W (18) | Signed remaining phase length being tracked |

## Verification
The hardest conditions to reach are a counter byte write landing on the same edge as the last byte, and a command arriving while a transfer is parked waiting for enable. The stimulus reaches the first by holding byte_valid high for a known length, so the finishing edge is known in advance, and timing the host write to that edge. It reaches the second by issuing the start with dma_en low and then rewriting the shadows and issuing a reload command before raising enable. The all-zero count runs as a full 65536-byte transfer, so the encoding of 65536 is checked through to completion.

// File: rtl/tcnt_pkg.sv
package tcnt_pkg;
    localparam int DEF_CNT_W = 16;
    localparam int DEF_PH_W  = 18;
    localparam int DEF_CAP   = 32;

    localparam logic [6:0] OP_XFER   = 7'h10;
    localparam logic [7:0] INTR_DONE = 8'h10;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PEND = 2'd1,
        ST_ACT  = 2'd2
    } xfer_st_e;
endpackage

// File: rtl/tcnt_shadow.sv
module tcnt_shadow #(
    parameter int CNT_W = 16,
    localparam int NB = CNT_W / 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NB-1:0]    lane_wr,
    input  logic [7:0]       data,
    output logic [CNT_W-1:0] shadow
);
    for (genvar i = 0; i < NB; i++) begin : g_lane
        logic [7:0] byte_q;
        always_ff @(posedge clk) begin
            if (rst)             byte_q <= '0;
            else if (lane_wr[i]) byte_q <= data;
        end
        assign shadow[8*i +: 8] = byte_q;
    end
endmodule

// File: rtl/tcnt_len.sv
module tcnt_len #(
    parameter int CNT_W = 16,
    parameter int PH_W  = 18,
    parameter int CAP   = 32,
    localparam int LEN_W = CNT_W + 1,
    localparam int MW = (LEN_W > PH_W) ? LEN_W : PH_W
) (
    input  logic                   cmd_mode,
    input  logic [CNT_W-1:0]       count,
    input  logic signed [PH_W-1:0] phase,
    output logic [LEN_W-1:0]       len
);
    logic [LEN_W-1:0] eff;
    logic [PH_W-1:0]  mag;
    logic [MW-1:0]    lim, effw, pick;

    always_comb begin
        eff  = (count == '0) ? (LEN_W'(1) << CNT_W) : {1'b0, count};
        mag  = phase[PH_W-1] ? (~phase + 1'b1) : phase;
        lim  = cmd_mode ? MW'(CAP) : MW'(mag);
        effw = MW'(eff);
        pick = (effw < lim) ? effw : lim;
        len  = LEN_W'(pick);
    end
endmodule

// File: rtl/tcnt_seq.sv
module tcnt_seq
    import tcnt_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PH_W  = 18,
    parameter int CAP   = 32,
    localparam int LEN_W = CNT_W + 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   reload,
    input  logic                   start,
    input  logic                   cnt_wr,
    input  logic [CNT_W-1:0]       shadow,
    input  logic [LEN_W-1:0]       len_in,
    input  logic signed [PH_W-1:0] ph_in,
    input  logic                   cmd_mode,
    input  logic                   dma_en,
    input  logic                   byte_valid,
    output logic                   byte_ready,
    output logic                   done,
    output logic                   busy,
    output logic [CNT_W-1:0]       live,
    output logic [LEN_W-1:0]       len_q,
    output logic                   tc,
    output logic [7:0]             intr,
    output logic signed [PH_W-1:0] ph_left
);
    xfer_st_e         st;
    logic [LEN_W-1:0] rem;
    logic             cm_q;
    logic             accept;

    assign busy       = (st != ST_IDLE);
    assign byte_ready = (st == ST_ACT) && (rem != '0);
    assign accept     = byte_ready && byte_valid;
    assign done       = (st == ST_ACT) &&
                        ((rem == '0) || ((rem == LEN_W'(1)) && byte_valid));

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= ST_IDLE; live <= '0; rem <= '0; len_q <= '0;
            tc <= 1'b0; intr <= '0; ph_left <= '0; cm_q <= 1'b0;
        end else begin
            if (cnt_wr) tc <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (reload) live <= shadow;
                    if (start) begin
                        len_q   <= len_in;
                        rem     <= len_in;
                        ph_left <= ph_in;
                        cm_q    <= cmd_mode;
                        tc      <= 1'b0;
                        st      <= dma_en ? ST_ACT : ST_PEND;
                    end
                end
                ST_PEND: if (dma_en) st <= ST_ACT;
                ST_ACT: begin
                    if (accept) begin
                        rem  <= rem - 1'b1;
                        live <= live - 1'b1;
                        if (!cm_q)
                            ph_left <= ph_left[PH_W-1] ? ph_left + 1'b1 : ph_left - 1'b1;
                    end
                    if (done) begin
                        st   <= ST_IDLE;
                        tc   <= 1'b1;
                        intr <= INTR_DONE;
                        live <= '0;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    p_tc_clear_r2: assert property (@(posedge clk) disable iff (rst)
        (cnt_wr && !done) |=> !tc);
    p_reload_r3: assert property (@(posedge clk) disable iff (rst)
        (reload && !busy) |=> (live == $past(shadow)));
    p_rem_bound_r4: assert property (@(posedge clk) disable iff (rst)
        rem <= len_q);
    p_cmd_cap_r5: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && cmd_mode) |=> (len_q <= LEN_W'(CAP)));
    p_hold_pend_r6: assert property (@(posedge clk) disable iff (rst)
        (st == ST_PEND && !dma_en) |=> (st == ST_PEND && !byte_ready && !tc));
    p_step_r7: assert property (@(posedge clk) disable iff (rst)
        (accept && !done) |=> (live == $past(live) - 1'b1));
    p_finish_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> (tc && intr == INTR_DONE && live == '0 && !busy));
endmodule

// File: rtl/tcnt_top.sv
module tcnt_top
    import tcnt_pkg::*;
#(
    parameter int CNT_W = DEF_CNT_W,
    parameter int PH_W  = DEF_PH_W,
    parameter int CAP   = DEF_CAP,
    localparam int NB    = CNT_W / 8,
    localparam int SEL_W = $clog2(NB + 1),
    localparam int LEN_W = CNT_W + 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   host_wr,
    input  logic [SEL_W-1:0]       host_sel,
    input  logic [7:0]             host_data,
    input  logic                   cmd_mode,
    input  logic signed [PH_W-1:0] phase_rem,
    input  logic                   dma_en,
    input  logic                   byte_valid,
    output logic                   byte_ready,
    output logic                   done,
    output logic [CNT_W-1:0]       live_count,
    output logic [LEN_W-1:0]       xfer_len,
    output logic                   tc,
    output logic [7:0]             intr_code,
    output logic signed [PH_W-1:0] phase_left
);
    logic [NB-1:0]    lane_wr;
    logic [CNT_W-1:0] shadow;
    logic [LEN_W-1:0] len_calc;
    logic             cmd_wr, reload, start, busy;

    for (genvar i = 0; i < NB; i++) begin : g_dec
        assign lane_wr[i] = host_wr && (host_sel == SEL_W'(i));
    end

    assign cmd_wr = host_wr && (host_sel == SEL_W'(NB));
    assign reload = cmd_wr && host_data[7] && !busy;
    assign start  = reload && (host_data[6:0] == OP_XFER);

    tcnt_shadow #(.CNT_W(CNT_W)) u_shadow (
        .clk(clk), .rst(rst), .lane_wr(lane_wr), .data(host_data), .shadow(shadow)
    );

    tcnt_len #(.CNT_W(CNT_W), .PH_W(PH_W), .CAP(CAP)) u_len (
        .cmd_mode(cmd_mode), .count(shadow), .phase(phase_rem), .len(len_calc)
    );

    tcnt_seq #(.CNT_W(CNT_W), .PH_W(PH_W), .CAP(CAP)) u_seq (
        .clk(clk), .rst(rst), .reload(reload), .start(start), .cnt_wr(|lane_wr),
        .shadow(shadow), .len_in(len_calc), .ph_in(phase_rem), .cmd_mode(cmd_mode),
        .dma_en(dma_en), .byte_valid(byte_valid), .byte_ready(byte_ready),
        .done(done), .busy(busy), .live(live_count), .len_q(xfer_len), .tc(tc),
        .intr(intr_code), .ph_left(phase_left)
    );

    p_ignore_busy_r9: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && busy && !byte_ready) |=> $stable(live_count));
    p_done_wins_r10: assert property (@(posedge clk) disable iff (rst)
        (done && (|lane_wr)) |=> tc);
endmodule

// File: tb/tcnt_top_tb.sv
`timescale 1ns/1ps
module tcnt_top_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic host_wr = 1'b0;
    logic [1:0] host_sel = 2'd0;
    logic [7:0] host_data = 8'd0;
    logic cmd_mode = 1'b0;
    logic signed [17:0] phase_rem = '0;
    logic dma_en = 1'b1;
    logic byte_valid = 1'b0;
    logic byte_ready, done, tc;
    logic [15:0] live_count;
    logic [16:0] xfer_len;
    logic [7:0] intr_code;
    logic signed [17:0] phase_left;

    int errors = 0, checks = 0, cyc = 0, bv_pat = 0;
    bit finished = 0;

    // reference model state
    int m_sh = 0, m_live = 0, m_len = 0, m_rem = 0, m_ph = 0, m_st = 0, m_intr = 0;
    bit m_tc = 0, m_cm = 0;

    always #2 clk = ~clk;

    tcnt_top u_dut (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_sel(host_sel),
        .host_data(host_data), .cmd_mode(cmd_mode), .phase_rem(phase_rem),
        .dma_en(dma_en), .byte_valid(byte_valid), .byte_ready(byte_ready),
        .done(done), .live_count(live_count), .xfer_len(xfer_len), .tc(tc),
        .intr_code(intr_code), .phase_left(phase_left)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    always @(posedge clk) begin
        int cnt, lim;
        bit acc, fin;
        cyc++;
        if (rst) begin
            m_sh = 0; m_live = 0; m_len = 0; m_rem = 0; m_ph = 0;
            m_st = 0; m_intr = 0; m_tc = 0; m_cm = 0;
        end else begin
            acc = (m_st == 2) && (m_rem != 0) && byte_valid;
            fin = (m_st == 2) && ((m_rem == 0) || (m_rem == 1 && byte_valid));
            if (host_wr && host_sel == 0) begin m_sh = (m_sh & 'hFF00) | host_data; m_tc = 0; end
            if (host_wr && host_sel == 1) begin m_sh = (m_sh & 'h00FF) | (host_data << 8); m_tc = 0; end
            case (m_st)
                0: if (host_wr && host_sel == 2 && host_data[7]) begin
                       m_live = m_sh;
                       if (host_data[6:0] == 7'h10) begin
                           cnt = (m_live == 0) ? 65536 : m_live;
                           lim = cmd_mode ? 32 : ((phase_rem < 0) ? -int'(phase_rem) : int'(phase_rem));
                           m_len = (cnt < lim) ? cnt : lim;
                           m_rem = m_len; m_ph = int'(phase_rem); m_cm = cmd_mode;
                           m_tc = 0; m_st = dma_en ? 2 : 1;
                       end
                   end
                1: if (dma_en) m_st = 2;
                default: begin
                    if (acc) begin
                        m_rem--; m_live = (m_live - 1) & 'hFFFF;
                        if (!m_cm) m_ph = (m_ph < 0) ? m_ph + 1 : m_ph - 1;
                    end
                    if (fin) begin m_st = 0; m_tc = 1; m_intr = 'h10; m_live = 0; end
                end
            endcase
        end
    end

    // per-cycle comparison, one ns after the falling edge
    always begin
        @(negedge clk); #1;
        if (!finished) begin
            chk("R7 live_count", live_count, m_live);
            chk("R6 tc", tc, m_tc);
            chk("R8 intr_code", intr_code, m_intr);
            chk("R6 byte_ready", byte_ready, (m_st == 2 && m_rem != 0));
            chk("R8 done", done, (m_st == 2) && (m_rem == 0 || (m_rem == 1 && byte_valid)));
            chk("R4 xfer_len", xfer_len, m_len);
            chk("R7 phase_left", phase_left, m_ph);
        end
    end

    always @(negedge clk) begin
        case (bv_pat)
            1: byte_valid <= 1'b1;
            2: byte_valid <= cyc[0];
            3: byte_valid <= (cyc % 3 == 0);
            default: byte_valid <= 1'b0;
        endcase
    end

    task automatic hwr(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_sel = sel; host_data = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic set_count(input int c);
        hwr(2'd0, 8'(c)); hwr(2'd1, 8'(c >> 8));
    endtask

    task automatic wait_idle();
        while (m_st != 0) @(negedge clk);
        @(negedge clk); #1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #1;
        chk("R1 reset live_count", live_count, 0);
        chk("R1 reset tc", tc, 0);
        chk("R1 reset xfer_len", xfer_len, 0);

        set_count('h1234); #1;
        chk("R2 shadow write leaves live_count", live_count, 0);
        hwr(2'd2, 8'h80); #1;
        chk("R3 DMA reload", live_count, 'h1234);
        set_count(5);
        hwr(2'd2, 8'h10); #1;
        chk("R3 no reload without DMA flag", live_count, 'h1234);
        hwr(2'd2, 8'h00);

        // data-in, count 5 clamped to phase 3, alternating valid
        phase_rem = 18'sd3; bv_pat = 2;
        hwr(2'd2, 8'h90); #1;
        chk("R4 len = min(count,phase)", xfer_len, 3);
        wait_idle();
        chk("R8 tc after completion", tc, 1);
        chk("R8 intr code", intr_code, 'h10);

        // toward device, count 300, phase -10
        bv_pat = 0; set_count(300); phase_rem = -18'sd10; bv_pat = 1;
        hwr(2'd2, 8'h90); #1;
        chk("R4 len with negative phase", xfer_len, 10);
        wait_idle();
        chk("R7 phase reaches zero", phase_left, 0);

        // pending while enable low, command ignored while pending
        bv_pat = 0; set_count(7); phase_rem = 18'sd20; dma_en = 1'b0;
        hwr(2'd2, 8'h90);
        repeat (4) @(negedge clk); #1;
        chk("R6 ready low while pending", byte_ready, 0);
        set_count(64);
        hwr(2'd2, 8'h80); #1;
        chk("R9 command ignored while pending", live_count, 7);
        dma_en = 1'b1; bv_pat = 3;
        wait_idle();

        // command mode clamp
        bv_pat = 0; set_count(100); cmd_mode = 1'b1; phase_rem = 18'sd5; bv_pat = 1;
        hwr(2'd2, 8'h90); #1;
        chk("R5 command cap", xfer_len, 32);
        wait_idle();
        chk("R7 phase held in command mode", phase_left, 5);
        cmd_mode = 1'b0;

        // counter write on the finishing edge
        bv_pat = 0; set_count(4); phase_rem = 18'sd4; bv_pat = 1;
        hwr(2'd2, 8'h90);
        repeat (2) @(negedge clk);
        hwr(2'd0, 8'h09);
        wait_idle();
        chk("R10 completion wins over byte write", tc, 1);

        // zero phase -> zero length
        bv_pat = 0; set_count(9); phase_rem = 18'sd0;
        hwr(2'd2, 8'h90);
        wait_idle();
        chk("R8 zero length completes", tc, 1);

        // zero count means 65536
        set_count(0); phase_rem = 18'sd100000; bv_pat = 1;
        hwr(2'd2, 8'h90); #1;
        chk("R4 zero count is 65536", xfer_len, 65536);
        wait_idle();
        chk("R8 full length done", tc, 1);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule